// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is the boundary register placed between a chip's core logic and a small group of I/O pads. It handles four kinds of pad: input-only, output-only, tri-state output, and bidirectional with tri-state. Each pad gets as many scan cells as it has observable signals. Together the cells form one serial chain. The chain is loaded in parallel from the live pad and core signals and shifted between a serial input and a serial output. An update register, loaded from the chain in parallel, holds the pattern that is applied to the pins.

An external TAP controller drives the block. It supplies the capture, shift and update strobes and the current instruction. The block only responds while that instruction selects the boundary register, which is the external-test code or the sample/preload code. Under external test, the update register drives the pad outputs, the pad enables and the core-side inputs. Under any other instruction, signals pass straight through between core and pads.

Top module: `bscan_chain`

## Requirements
- R1: The chain is N_IN + N_OUT + 2*N_TRI + 3*N_BD cells long, which is 7 at the defaults. Bit positions are laid out in this order: input-pad cells first, then output-pad cells, then tri-state pairs (data at the even offset, enable above it), then bidirectional triples (pad input, data, enable). A pattern shifted in returns unchanged after exactly that many further shifts.
- R2: On the capture strobe, with the instruction at 0 (external test) or 2 (sample/preload), the chain loads the pad inputs, core data outputs and core enables into their cells.
- R3: On each clock with the shift strobe high and a boundary instruction selected, the chain moves one place toward `tdo`. `tdi` enters the top bit, and `tdo` always shows bit 0.
- R4: The update register copies the chain only on the update strobe under a boundary instruction. Shifting never changes what is driven onto the pins.
- R5: With any instruction other than 0, each pad output and enable follows its core signal, and each core-side input follows its pad, including during capture and shift.
- R6: With instruction 0, every pad output, pad enable and core-side input takes its value from its cell in the update register.
- R7: Reset (`rst_n` low at a clock edge) clears both the chain and the update register to zero.
- R8: Under an instruction other than 0 or 2, the capture, shift and update strobes leave the chain and the update register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low test reset |
| capture_en | input | 1 | Capture strobe from TAP |
| shift_en | input | 1 | Shift strobe from TAP |
| update_en | input | 1 | Update strobe from TAP |
| instr | input | IR_W | Current instruction |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| in_pad_i | input | N_IN | Input pads, pad side |
| in_core_o | output | N_IN | Input pads, core side |
| out_core_i | input | N_OUT | Output pads, core data |
| out_pad_o | output | N_OUT | Output pads, pad data |
| tri_core_i | input | N_TRI | Tri-state pads, core data |
| tri_core_oe_i | input | N_TRI | Tri-state pads, core enable |
| tri_pad_o | output | N_TRI | Tri-state pads, pad data |
| tri_pad_oe | output | N_TRI | Tri-state pads, pad enable |
| bd_pad_i | input | N_BD | Bidirectional pads, pad input |
| bd_core_o | output | N_BD | Bidirectional pads, core-side input |
| bd_core_i | input | N_BD | Bidirectional pads, core data |
| bd_core_oe_i | input | N_BD | Bidirectional pads, core enable |
| bd_pad_o | output | N_BD | Bidirectional pads, pad data |
| bd_pad_oe | output | N_BD | Bidirectional pads, pad enable |

## Verification
The hardest condition to observe from the ports is a chain that holds one pattern while the update register holds another. The stimulus builds this condition directly. It preloads one pattern under sample and updates it. It then switches to external test and shifts in a second pattern without an update strobe. The pins must keep the first pattern, and `tdo` must return the first pattern, until the update strobe arrives. The ignored-strobe case is handled the same way. Strobes are pulsed under an unrelated instruction, and the untouched state is then read back by switching to external test and to sample.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  function automatic int chain_len(input int ni, input int no, input int nt, input int nb);
    return ni + no + 2 * nt + 3 * nb;
  endfunction

  function automatic int out_base(input int ni);
    return ni;
  endfunction

  function automatic int tri_base(input int ni, input int no);
    return ni + no;
  endfunction

  function automatic int bd_base(input int ni, input int no, input int nt);
    return ni + no + 2 * nt;
  endfunction

endpackage

// File: rtl/bscan_ir_decode.sv
module bscan_ir_decode #(
  parameter int IR_W        = 4,
  parameter int EXTEST_CODE = 0,
  parameter int SAMPLE_CODE = 2
) (
  input  logic [IR_W-1:0] instr,
  input  logic            capture_en,
  input  logic            shift_en,
  input  logic            update_en,
  output logic            sel,
  output logic            extest,
  output logic            cap_fire,
  output logic            shift_fire,
  output logic            upd_fire
);
  always_comb begin
    extest     = (instr == IR_W'(EXTEST_CODE));
    sel        = extest || (instr == IR_W'(SAMPLE_CODE));
    cap_fire   = sel && capture_en;
    shift_fire = sel && shift_en && !capture_en;
    upd_fire   = sel && update_en;
  end
endmodule

// File: rtl/bscan_cell_reg.sv
module bscan_cell_reg #(
  parameter int L = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_fire,
  input  logic         shift_fire,
  input  logic         upd_fire,
  input  logic         tdi,
  input  logic [L-1:0] cap_vec,
  output logic [L-1:0] sr_q,
  output logic [L-1:0] upd_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      upd_q <= '0;
    end else begin
      if (cap_fire)        sr_q <= cap_vec;
      else if (shift_fire) sr_q <= {tdi, sr_q[L-1:1]};
      if (upd_fire)        upd_q <= sr_q;
    end
  end

  // R2 capture loads the parallel vector
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> sr_q == $past(cap_vec));
  // R3 tdi enters the top cell
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> sr_q[L-1] == $past(tdi));
  // R3 the rest moves one place toward tdo
  a_r3_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> sr_q[L-2:0] == $past(sr_q[L-1:1]));
  // R4 update register holds without strobe
  a_r4_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(upd_q));
  // R4 update copies the chain
  a_r4_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> upd_q == $past(sr_q));
  // R7 reset clears both registers
  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (upd_q == '0) && (sr_q == '0));
endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
  import bscan_pkg::*;
#(
  parameter int N_IN  = 1,
  parameter int N_OUT = 1,
  parameter int N_TRI = 1,
  parameter int N_BD  = 1,
  localparam int L    = chain_len(N_IN, N_OUT, N_TRI, N_BD),
  localparam int OB   = out_base(N_IN),
  localparam int TB   = tri_base(N_IN, N_OUT),
  localparam int BB   = bd_base(N_IN, N_OUT, N_TRI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extest,
  input  logic [L-1:0]     upd_q,
  input  logic [N_IN-1:0]  in_pad_i,
  output logic [N_IN-1:0]  in_core_o,
  input  logic [N_OUT-1:0] out_core_i,
  output logic [N_OUT-1:0] out_pad_o,
  input  logic [N_TRI-1:0] tri_core_i,
  input  logic [N_TRI-1:0] tri_core_oe_i,
  output logic [N_TRI-1:0] tri_pad_o,
  output logic [N_TRI-1:0] tri_pad_oe,
  input  logic [N_BD-1:0]  bd_pad_i,
  output logic [N_BD-1:0]  bd_core_o,
  input  logic [N_BD-1:0]  bd_core_i,
  input  logic [N_BD-1:0]  bd_core_oe_i,
  output logic [N_BD-1:0]  bd_pad_o,
  output logic [N_BD-1:0]  bd_pad_oe
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign in_core_o[i] = extest ? upd_q[i] : in_pad_i[i];
  end
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign out_pad_o[i] = extest ? upd_q[OB + i] : out_core_i[i];
  end
  for (genvar i = 0; i < N_TRI; i++) begin : g_tri
    assign tri_pad_o[i]  = extest ? upd_q[TB + 2*i]     : tri_core_i[i];
    assign tri_pad_oe[i] = extest ? upd_q[TB + 2*i + 1] : tri_core_oe_i[i];
  end
  for (genvar i = 0; i < N_BD; i++) begin : g_bd
    assign bd_core_o[i] = extest ? upd_q[BB + 3*i]     : bd_pad_i[i];
    assign bd_pad_o[i]  = extest ? upd_q[BB + 3*i + 1] : bd_core_i[i];
    assign bd_pad_oe[i] = extest ? upd_q[BB + 3*i + 2] : bd_core_oe_i[i];
  end

  // R5 pass-through of first output and bidirectional pad
  a_r5_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !extest |-> (out_pad_o[0] == out_core_i[0]) && (bd_core_o[0] == bd_pad_i[0]));
  // R6 external test drives the pins from the update register
  a_r6_extest_drive: assert property (@(posedge clk) disable iff (!rst_n)
    extest |-> (in_core_o[0] == upd_q[0]) && (tri_pad_oe[0] == upd_q[TB + 1]));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN        = 1,
  parameter int N_OUT       = 1,
  parameter int N_TRI       = 1,
  parameter int N_BD        = 1,
  parameter int IR_W        = 4,
  parameter int EXTEST_CODE = 0,
  parameter int SAMPLE_CODE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic [IR_W-1:0]  instr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  in_pad_i,
  output logic [N_IN-1:0]  in_core_o,
  input  logic [N_OUT-1:0] out_core_i,
  output logic [N_OUT-1:0] out_pad_o,
  input  logic [N_TRI-1:0] tri_core_i,
  input  logic [N_TRI-1:0] tri_core_oe_i,
  output logic [N_TRI-1:0] tri_pad_o,
  output logic [N_TRI-1:0] tri_pad_oe,
  input  logic [N_BD-1:0]  bd_pad_i,
  output logic [N_BD-1:0]  bd_core_o,
  input  logic [N_BD-1:0]  bd_core_i,
  input  logic [N_BD-1:0]  bd_core_oe_i,
  output logic [N_BD-1:0]  bd_pad_o,
  output logic [N_BD-1:0]  bd_pad_oe
);
  localparam int L  = chain_len(N_IN, N_OUT, N_TRI, N_BD);
  localparam int OB = out_base(N_IN);
  localparam int TB = tri_base(N_IN, N_OUT);
  localparam int BB = bd_base(N_IN, N_OUT, N_TRI);

  logic         sel, extest, cap_fire, shift_fire, upd_fire;
  logic [L-1:0] cap_vec, sr_q, upd_q;

  bscan_ir_decode #(
    .IR_W(IR_W), .EXTEST_CODE(EXTEST_CODE), .SAMPLE_CODE(SAMPLE_CODE)
  ) u_dec (
    .instr(instr), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .sel(sel), .extest(extest),
    .cap_fire(cap_fire), .shift_fire(shift_fire), .upd_fire(upd_fire)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_cap_in
    assign cap_vec[i] = in_pad_i[i];
  end
  for (genvar i = 0; i < N_OUT; i++) begin : g_cap_out
    assign cap_vec[OB + i] = out_core_i[i];
  end
  for (genvar i = 0; i < N_TRI; i++) begin : g_cap_tri
    assign cap_vec[TB + 2*i]     = tri_core_i[i];
    assign cap_vec[TB + 2*i + 1] = tri_core_oe_i[i];
  end
  for (genvar i = 0; i < N_BD; i++) begin : g_cap_bd
    assign cap_vec[BB + 3*i]     = bd_pad_i[i];
    assign cap_vec[BB + 3*i + 1] = bd_core_i[i];
    assign cap_vec[BB + 3*i + 2] = bd_core_oe_i[i];
  end

  bscan_cell_reg #(.L(L)) u_cells (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .shift_fire(shift_fire),
    .upd_fire(upd_fire), .tdi(tdi), .cap_vec(cap_vec),
    .sr_q(sr_q), .upd_q(upd_q)
  );

  assign tdo = sr_q[0];

  bscan_pad_mux #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_TRI(N_TRI), .N_BD(N_BD)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .extest(extest), .upd_q(upd_q),
    .in_pad_i(in_pad_i), .in_core_o(in_core_o),
    .out_core_i(out_core_i), .out_pad_o(out_pad_o),
    .tri_core_i(tri_core_i), .tri_core_oe_i(tri_core_oe_i),
    .tri_pad_o(tri_pad_o), .tri_pad_oe(tri_pad_oe),
    .bd_pad_i(bd_pad_i), .bd_core_o(bd_core_o),
    .bd_core_i(bd_core_i), .bd_core_oe_i(bd_core_oe_i),
    .bd_pad_o(bd_pad_o), .bd_pad_oe(bd_pad_oe)
  );

  // R8 strobes under an unrelated instruction touch nothing
  a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (instr != IR_W'(EXTEST_CODE) && instr != IR_W'(SAMPLE_CODE))
      |=> $stable(sr_q) && $stable(upd_q));
  // R3 tdo mirrors the lowest cell
  a_r3_tdo_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> tdo == $past(sr_q[1]));
endmodule

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
  logic [3:0] instr = 4'd2;
  logic       tdi = 1'b0;
  logic       tdo;
  logic [0:0] in_pad_i = '0, out_core_i = '0, tri_core_i = '0, tri_core_oe_i = '0;
  logic [0:0] bd_pad_i = '0, bd_core_i = '0, bd_core_oe_i = '0;
  logic [0:0] in_core_o, out_pad_o, tri_pad_o, tri_pad_oe, bd_core_o, bd_pad_o, bd_pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bscan_chain u_bscan_chain (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .instr(instr), .tdi(tdi), .tdo(tdo),
    .in_pad_i(in_pad_i), .in_core_o(in_core_o),
    .out_core_i(out_core_i), .out_pad_o(out_pad_o),
    .tri_core_i(tri_core_i), .tri_core_oe_i(tri_core_oe_i),
    .tri_pad_o(tri_pad_o), .tri_pad_oe(tri_pad_oe),
    .bd_pad_i(bd_pad_i), .bd_core_o(bd_core_o),
    .bd_core_i(bd_core_i), .bd_core_oe_i(bd_core_oe_i),
    .bd_pad_o(bd_pad_o), .bd_pad_oe(bd_pad_oe)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected pins: layout bit0 in, bit1 out, bit2/3 tri data/en, bit4/5/6 bd in/data/en
  task automatic check_pins(input bit ext, input logic [6:0] u, input string req);
    #2;
    check(in_core_o,  ext ? u[0] : in_pad_i,      req);
    check(out_pad_o,  ext ? u[1] : out_core_i,    req);
    check(tri_pad_o,  ext ? u[2] : tri_core_i,    req);
    check(tri_pad_oe, ext ? u[3] : tri_core_oe_i, req);
    check(bd_core_o,  ext ? u[4] : bd_pad_i,      req);
    check(bd_pad_o,   ext ? u[5] : bd_core_i,     req);
    check(bd_pad_oe,  ext ? u[6] : bd_core_oe_i,  req);
  endtask

  task automatic set_pads(input logic [6:0] v);
    in_pad_i = v[0]; out_core_i = v[1]; tri_core_i = v[2]; tri_core_oe_i = v[3];
    bd_pad_i = v[4]; bd_core_i = v[5]; bd_core_oe_i = v[6];
  endtask

  task automatic shift_chain(input logic [6:0] din, output logic [6:0] dout);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      dout[i] = tdo;
      tdi = din[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_capture();
    @(negedge clk); capture_en = 1'b1;
    @(negedge clk); capture_en = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_en = 1'b1;
    @(negedge clk); update_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [6:0] d;
    instr = 4'd2;
    do_reset();
    check(tdo, 1'b0, "R7 tdo after reset");
    set_pads(7'b1001101);
    check_pins(1'b0, 7'b0, "R5 pass-through after reset");
    instr = 4'd0;
    check_pins(1'b1, 7'b0, "R7 update register zero");
    instr = 4'd2;
    shift_chain(7'b0, d);
    check(d, 7'b0, "R7 chain zero");
  endtask

  task automatic t_sample();
    logic [6:0] d;
    instr = 4'd2;
    set_pads(7'b1001101);
    pulse_capture();
    check_pins(1'b0, 7'b0, "R5 sample leaves pins");
    shift_chain(7'b0, d);
    check(d, 7'b1001101, "R2 captured vector");
    set_pads(7'b0110010);
    pulse_capture();
    shift_chain(7'b1010011, d);
    check(d, 7'b0110010, "R2 second capture");
    shift_chain(7'b0, d);
    check(d, 7'b1010011, "R1 R3 round trip length 7");
  endtask

  task automatic t_preload_extest();
    logic [6:0] d;
    instr = 4'd2;
    shift_chain(7'b0110101, d);
    check_pins(1'b0, 7'b0, "R5 preload shift pass-through");
    pulse_update();
    check_pins(1'b0, 7'b0, "R5 preload update pass-through");
    instr = 4'd0;
    check_pins(1'b1, 7'b0110101, "R6 extest drives preload");
    set_pads(7'b1111111);
    check_pins(1'b1, 7'b0110101, "R6 pad change ignored");
    shift_chain(7'b1001010, d);
    check(d, 7'b0110101, "R3 chain held preload");
    check_pins(1'b1, 7'b0110101, "R4 no update before strobe");
    pulse_update();
    check_pins(1'b1, 7'b1001010, "R4 update applies new pattern");
  endtask

  task automatic t_ignore();
    logic [6:0] d;
    instr = 4'd5;
    set_pads(7'b0000000);
    pulse_capture();
    shift_chain(7'b1111111, d);
    pulse_update();
    instr = 4'd0;
    check_pins(1'b1, 7'b1001010, "R8 update register untouched");
    instr = 4'd2;
    shift_chain(7'b0, d);
    check(d, 7'b1001010, "R8 chain untouched");
  endtask

  task automatic t_reset_mid();
    instr = 4'd0;
    do_reset();
    check_pins(1'b1, 7'b0, "R7 reset clears driven pattern");
    check(tdo, 1'b0, "R7 reset clears chain");
  endtask

  initial begin
    t_reset_state();
    t_sample();
    t_preload_extest();
    t_ignore();
    t_reset_mid();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule